// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable logic device. It takes two sum terms from an OR array and a set of product terms from an AND array. Static configuration bits then decide how the cell uses them. The cell holds one storage element that works as a D flip-flop or as a J-K flip-flop, and a product term can change that choice from one cycle to the next. The cell also selects the clock source and the output-enable source, and it applies a polarity control to the combinational path. It feeds the register state and the pin value back to the array.

The cell has five configurations. In the combinational I/O configuration the pin follows one array sum directly. The register is still in use: it keeps clocking from the second sum and presents its state on its own feedback output. Clock sources are the shared external clock pin and a per-cell product-term clock. The cell runs from one system clock and samples both sources, so a register update happens on the system edge that first sees a rising edge of the selected source. Preset and reset product terms force the register state straight away.

Top module: `omc_cell`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the register holds 0 and `fb_reg` reads 0. A clock source that is already high at reset release does not count as a rising edge.
- R2: With `cfg_mode`=0 (registered output), `pin_out` is the inverse of the register state, `fb_reg` is the register state, and the register loads from `sum_reg`.
- R3: With `cfg_mode`=2 (combinational I/O with buried register), `pin_out` equals `sum_comb` XOR `cfg_pol_inv`. The register still updates from `sum_reg` on clock events, and its state appears on `fb_reg`.
- R4: With `cfg_mode`=3 (dedicated I/O), `pin_out` equals `sum_comb` XOR `cfg_pol_inv`. The register ignores clock events and holds its state.
- R5: With `cfg_mode`=1 (registered input), `pin_oe` is 0, `pin_out` is 0, the register loads from `pin_in`, and `fb_pin` equals `pin_in`.
- R6: With `cfg_mode`=4 (dedicated input), `pin_oe` and `pin_out` are 0, `fb_pin` equals `pin_in`, and the register holds. Mode codes 5 to 7 behave like code 4.
- R7: With `pt_fc`=0, a clock event loads the data input into the register.
- R8: With `pt_fc`=1, a clock event applies J-K rules to J (the data input) and K (`pt_k`): 00 holds, 01 clears, 10 sets and 11 toggles. `pt_fc` may change between any two events.
- R9: `cfg_clk_pt`=0 takes clock events from rising edges of `ext_clk`, and `cfg_clk_pt`=1 takes them from rising edges of `pt_clk`. Edges on the unselected source have no effect, and the register updates at the first system edge that samples the new high level.
- R10: In modes 0, 2 and 3, `pin_oe` is `ext_oe` when `cfg_oe_pt`=0 and `pt_oe` when `cfg_oe_pt`=1. `fb_pin` is `pin_out` while `pin_oe` is 1 and `pin_in` while it is 0.
- R11: `pt_preset` forces the register to 1 and `pt_reset` forces it to 0, visible on `fb_reg` in the same cycle. Both override clock events, and reset wins over preset. The forced value remains after release.
- R12: `cfg_pol_inv` has no effect in mode 0: `pin_out` remains the inverse of `fb_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Cell configuration code (0 to 4, see requirements) |
| cfg_pol_inv | input | 1 | Invert the combinational path |
| cfg_clk_pt | input | 1 | Clock the register from the product-term clock |
| cfg_oe_pt | input | 1 | Take the output enable from the product term |
| ext_clk | input | 1 | Shared external clock pin |
| ext_oe | input | 1 | Shared output-enable pin |
| sum_reg | input | 1 | Array sum feeding D or J |
| sum_comb | input | 1 | Array sum feeding the combinational path |
| pt_k | input | 1 | K product term |
| pt_fc | input | 1 | Mode term: 0 selects D, 1 selects J-K |
| pt_clk | input | 1 | Product-term clock |
| pt_oe | input | 1 | Product-term output enable |
| pt_preset | input | 1 | Product-term preset |
| pt_reset | input | 1 | Product-term reset |
| pin_in | input | 1 | Value seen on the pad |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad driver enable (0 means high impedance) |
| fb_reg | output | 1 | Register state feedback to the array |
| fb_pin | output | 1 | Pin feedback to the array |

## Verification
The hardest case to reach is a register that must keep its own timing while the pin does something unrelated. Examples are a buried register in combinational I/O, a clock event on the unselected source, and a `pt_fc` flip between two events. The bench gets there by pulsing each clock source as a separate low-then-high pair. Between pulses it changes `pt_fc`, the clock select and the combinational sum, then checks `fb_reg` and `pin_out` against separately computed values. A sweep over every mode, polarity, enable source and clock source follows. It drives pseudo-random array terms, with preset and reset kept rare, against a cycle model.

// File: rtl/omc_pkg.sv
`timescale 1ns/1ps
package omc_pkg;

    typedef enum logic [2:0] {
        CFG_REG_OUT = 3'd0,
        CFG_REG_IN  = 3'd1,
        CFG_COMB_IO = 3'd2,
        CFG_DED_IO  = 3'd3,
        CFG_DED_IN  = 3'd4
    } cell_cfg_e;

    typedef struct packed {
        logic data;    // D, or J in J-K mode
        logic k;
        logic fc;      // 0: D, 1: J-K
        logic preset;
        logic reset;
    } reg_ctl_t;

    function automatic logic next_state(logic q, logic fc, logic j, logic k);
        logic n;
        if (!fc) begin
            n = j;
        end else begin
            case ({j, k})
                2'b00:   n = q;
                2'b01:   n = 1'b0;
                2'b10:   n = 1'b1;
                default: n = ~q;
            endcase
        end
        return n;
    endfunction

    function automatic logic cfg_clocks_reg(cell_cfg_e m);
        return (m == CFG_REG_OUT) || (m == CFG_REG_IN) || (m == CFG_COMB_IO);
    endfunction

    function automatic logic cfg_input_only(cell_cfg_e m);
        return !((m == CFG_REG_OUT) || (m == CFG_COMB_IO) || (m == CFG_DED_IO));
    endfunction

endpackage

// File: rtl/omc_clk_sel.sv
`timescale 1ns/1ps
module omc_clk_sel (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic pt_clk,
    input  logic use_pt,
    input  logic allow,
    output logic evt
);
    logic prev_ext, prev_pt;
    logic ext_rise, pt_rise;

    // Sampled levels start high so a level already high at release is not an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ext <= 1'b1;
            prev_pt  <= 1'b1;
        end else begin
            prev_ext <= ext_clk;
            prev_pt  <= pt_clk;
        end
    end

    assign ext_rise = ext_clk & ~prev_ext;
    assign pt_rise  = pt_clk  & ~prev_pt;
    assign evt      = allow & (use_pt ? pt_rise : ext_rise);

    // R9: a rising edge needs a low sample in between
    assert_ext_single_R9: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);
    assert_pt_single_R9: assert property (@(posedge clk) disable iff (rst)
        pt_rise |=> !pt_rise);
endmodule

// File: rtl/omc_reg.sv
`timescale 1ns/1ps
module omc_reg
    import omc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evt,
    input  reg_ctl_t ctl,
    output logic     q
);
    logic q_reg, q_nxt;

    always_comb q_nxt = next_state(q_reg, ctl.fc, ctl.data, ctl.k);

    always_ff @(posedge clk) begin
        if (rst)             q_reg <= 1'b0;
        else if (ctl.reset)  q_reg <= 1'b0;
        else if (ctl.preset) q_reg <= 1'b1;
        else if (evt)        q_reg <= q_nxt;
    end

    // Forcing terms act without waiting for a clock event; reset dominates
    assign q = ctl.reset ? 1'b0 : (ctl.preset ? 1'b1 : q_reg);

    assert_hold_without_event_R9: assert property (@(posedge clk) disable iff (rst)
        (!evt && !ctl.preset && !ctl.reset) |=> (q_reg == $past(q_reg)));
    assert_d_load_R7: assert property (@(posedge clk) disable iff (rst)
        (evt && !ctl.fc && !ctl.preset && !ctl.reset) |=> (q_reg == $past(ctl.data)));
    assert_jk_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        (evt && ctl.fc && ctl.data && ctl.k && !ctl.preset && !ctl.reset)
        |=> (q_reg != $past(q_reg)));
    assert_reset_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl.reset && ctl.preset) |=> !q_reg);
endmodule

// File: rtl/omc_out.sv
`timescale 1ns/1ps
module omc_out
    import omc_pkg::*;
(
    input  cell_cfg_e mode,
    input  logic      pol_inv,
    input  logic      oe_sel_pt,
    input  logic      ext_oe,
    input  logic      pt_oe,
    input  logic      sum_comb,
    input  logic      q,
    input  logic      pin_in,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_pin
);
    logic oe_raw;

    always_comb begin
        oe_raw = oe_sel_pt ? pt_oe : ext_oe;
        case (mode)
            CFG_REG_OUT: begin
                pin_out = ~q;
                pin_oe  = oe_raw;
            end
            CFG_COMB_IO, CFG_DED_IO: begin
                pin_out = sum_comb ^ pol_inv;
                pin_oe  = oe_raw;
            end
            default: begin
                pin_out = 1'b0;
                pin_oe  = 1'b0;
            end
        endcase
        fb_pin = pin_oe ? pin_out : pin_in;
    end
endmodule

// File: rtl/omc_cell.sv
`timescale 1ns/1ps
module omc_cell
    import omc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_pol_inv,
    input  logic       cfg_clk_pt,
    input  logic       cfg_oe_pt,
    input  logic       ext_clk,
    input  logic       ext_oe,
    input  logic       sum_reg,
    input  logic       sum_comb,
    input  logic       pt_k,
    input  logic       pt_fc,
    input  logic       pt_clk,
    input  logic       pt_oe,
    input  logic       pt_preset,
    input  logic       pt_reset,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb_reg,
    output logic       fb_pin
);
    cell_cfg_e mode_e;
    reg_ctl_t  ctl;
    logic      evt;
    logic      q;

    assign mode_e = cell_cfg_e'(cfg_mode);

    always_comb begin
        ctl.data   = (mode_e == CFG_REG_IN) ? pin_in : sum_reg;
        ctl.k      = pt_k;
        ctl.fc     = pt_fc;
        ctl.preset = pt_preset;
        ctl.reset  = pt_reset;
    end

    omc_clk_sel u_clk (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ext_clk),
        .pt_clk  (pt_clk),
        .use_pt  (cfg_clk_pt),
        .allow   (cfg_clocks_reg(mode_e)),
        .evt     (evt)
    );

    omc_reg u_reg (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .ctl (ctl),
        .q   (q)
    );

    omc_out u_out (
        .mode      (mode_e),
        .pol_inv   (cfg_pol_inv),
        .oe_sel_pt (cfg_oe_pt),
        .ext_oe    (ext_oe),
        .pt_oe     (pt_oe),
        .sum_comb  (sum_comb),
        .q         (q),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .fb_pin    (fb_pin)
    );

    assign fb_reg = q;

    // R5 / R6: input-only configurations never drive the pad
    assert_input_only_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_input_only(mode_e) |-> !pin_oe);
    // R2 / R12: registered output carries the inverted state whatever the polarity bit
    assert_regout_inverted_R12: assert property (@(posedge clk) disable iff (rst)
        (mode_e == CFG_REG_OUT) |-> (pin_out == !fb_reg));
    // R4: dedicated configurations freeze the register unless forced
    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_clocks_reg(mode_e) && !pt_preset && !pt_reset)
        |=> ((fb_reg == $past(fb_reg)) || pt_preset || pt_reset));
endmodule

// File: tb/sim_omc_cell.sv
`timescale 1ns/1ps
module sim_omc_cell;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] mode = 3'd0;
    logic pol = 1'b0, clk_pt = 1'b0, oe_pt = 1'b0;
    logic ext_clk = 1'b0, ext_oe = 1'b0;
    logic sum_reg = 1'b0, sum_comb = 1'b0, pt_k = 1'b0, pt_fc = 1'b0;
    logic pt_clk = 1'b0, pt_oe = 1'b0, pt_preset = 1'b0, pt_reset = 1'b0;
    logic pin_in = 1'b0;
    logic pin_out, pin_oe, fb_reg, fb_pin;

    int n_chk = 0;
    int n_fail = 0;
    logic qm = 1'b0, pe = 1'b1, pp = 1'b1;
    logic [31:0] rs = 32'h1234_5678;

    always #2 clk = ~clk;

    omc_cell u0 (
        .clk(clk), .rst(rst), .cfg_mode(mode), .cfg_pol_inv(pol),
        .cfg_clk_pt(clk_pt), .cfg_oe_pt(oe_pt), .ext_clk(ext_clk), .ext_oe(ext_oe),
        .sum_reg(sum_reg), .sum_comb(sum_comb), .pt_k(pt_k), .pt_fc(pt_fc),
        .pt_clk(pt_clk), .pt_oe(pt_oe), .pt_preset(pt_preset), .pt_reset(pt_reset),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_reg(fb_reg),
        .fb_pin(fb_pin)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // Compare against the cycle model, then advance one system clock
    task automatic step(input string tag);
        logic qe, oe_e, po_e, fp_e, rise, j;
        #1;
        qe   = pt_reset ? 1'b0 : (pt_preset ? 1'b1 : qm);
        oe_e = (mode == 3'd0 || mode == 3'd2 || mode == 3'd3) ? (oe_pt ? pt_oe : ext_oe) : 1'b0;
        po_e = (mode == 3'd0) ? ~qe : ((mode == 3'd2 || mode == 3'd3) ? (sum_comb ^ pol) : 1'b0);
        fp_e = oe_e ? po_e : pin_in;
        if (!rst) begin
            chk(tag, "fb_reg", fb_reg, qe);
            chk(tag, "pin_oe", pin_oe, oe_e);
            chk(tag, "pin_out", pin_out, po_e);
            chk(tag, "fb_pin", fb_pin, fp_e);
        end
        @(posedge clk);
        if (rst) begin
            qm = 1'b0; pe = 1'b1; pp = 1'b1;
        end else begin
            rise = clk_pt ? (pt_clk & ~pp) : (ext_clk & ~pe);
            j = (mode == 3'd1) ? pin_in : sum_reg;
            if (pt_reset) qm = 1'b0;
            else if (pt_preset) qm = 1'b1;
            else if (rise && mode <= 3'd2) begin
                if (!pt_fc) qm = j;
                else if (j && pt_k) qm = ~qm;
                else if (j) qm = 1'b1;
                else if (pt_k) qm = 1'b0;
            end
            pe = ext_clk; pp = pt_clk;
        end
        @(negedge clk);
    endtask

    task automatic pulse(input logic use_pt, input string tag);
        if (use_pt) pt_clk = 1'b0; else ext_clk = 1'b0;
        step(tag);
        if (use_pt) pt_clk = 1'b1; else ext_clk = 1'b1;
        step(tag);
    endtask

    task automatic finish_run();
        if (n_chk - n_fail == n_chk) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        else $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset state, no edge from a source already high at release
        rst = 1'b1; ext_clk = 1'b1; sum_reg = 1'b1; mode = 3'd0;
        repeat (3) step("R1");
        rst = 1'b0;
        step("R1");
        chk("R1", "fb_reg after release", fb_reg, 1'b0);
        // R7 with R2: D loads on external edge, pin inverted
        pulse(1'b0, "R7");
        chk("R7", "fb_reg D=1", fb_reg, 1'b1);
        chk("R2", "pin_out inverted", pin_out, 1'b0);
        sum_reg = 1'b0; pulse(1'b0, "R7");
        chk("R7", "fb_reg D=0", fb_reg, 1'b0);
        // R8: J-K table and run-time mode switching
        pt_fc = 1'b1; sum_reg = 1'b1; pt_k = 1'b0; pulse(1'b0, "R8");
        chk("R8", "JK set", fb_reg, 1'b1);
        sum_reg = 1'b0; pulse(1'b0, "R8");
        chk("R8", "JK hold", fb_reg, 1'b1);
        sum_reg = 1'b1; pt_k = 1'b1; pulse(1'b0, "R8");
        chk("R8", "JK toggle to 0", fb_reg, 1'b0);
        pulse(1'b0, "R8");
        chk("R8", "JK toggle to 1", fb_reg, 1'b1);
        sum_reg = 1'b0; pulse(1'b0, "R8");
        chk("R8", "JK clear", fb_reg, 1'b0);
        pt_fc = 1'b0; sum_reg = 1'b1; pulse(1'b0, "R8");
        chk("R8", "switched to D", fb_reg, 1'b1);
        pt_fc = 1'b1; pt_k = 1'b1; pulse(1'b0, "R8");
        chk("R8", "switched back to JK toggle", fb_reg, 1'b0);
        // R9: product-term clock selected, external edges ignored
        clk_pt = 1'b1; pt_fc = 1'b0; sum_reg = 1'b1;
        pulse(1'b0, "R9");
        chk("R9", "ext edge ignored", fb_reg, 1'b0);
        pulse(1'b1, "R9");
        chk("R9", "pt edge loads", fb_reg, 1'b1);
        // R11: forcing terms
        pt_preset = 1'b1; step("R11");
        chk("R11", "preset", fb_reg, 1'b1);
        pt_reset = 1'b1; step("R11");
        chk("R11", "reset beats preset", fb_reg, 1'b0);
        pt_reset = 1'b0; pt_preset = 1'b0; step("R11");
        chk("R11", "reset persists", fb_reg, 1'b0);
        pt_preset = 1'b1; sum_reg = 1'b0; pulse(1'b1, "R11");
        chk("R11", "preset beats clock", fb_reg, 1'b1);
        pt_preset = 1'b0; step("R11");
        chk("R11", "preset persists", fb_reg, 1'b1);
        // R10: enable source and pin feedback
        oe_pt = 1'b0; ext_oe = 1'b1; pt_oe = 1'b0; step("R10");
        chk("R10", "pin_oe from pin", pin_oe, 1'b1);
        chk("R10", "fb_pin driven", fb_pin, 1'b0);
        oe_pt = 1'b1; pin_in = 1'b1; step("R10");
        chk("R10", "pin_oe from pterm", pin_oe, 1'b0);
        chk("R10", "fb_pin from pad", fb_pin, 1'b1);
        // R12: polarity ignored in registered output
        pol = 1'b1; oe_pt = 1'b0; step("R12");
        chk("R12", "pin_out ignores polarity", pin_out, 1'b0);
        // R3: buried register next to combinational path
        mode = 3'd2; pol = 1'b0; sum_comb = 1'b0; sum_reg = 1'b0; pulse(1'b1, "R3");
        chk("R3", "buried reg loads 0", fb_reg, 1'b0);
        sum_reg = 1'b1; pulse(1'b1, "R3");
        chk("R3", "buried reg loads 1", fb_reg, 1'b1);
        chk("R3", "pin follows sum", pin_out, 1'b0);
        pol = 1'b1; step("R3");
        chk("R3", "pin inverted", pin_out, 1'b1);
        // R4: dedicated I/O freezes the register
        mode = 3'd3; sum_reg = 1'b0; pulse(1'b1, "R4");
        chk("R4", "register held", fb_reg, 1'b1);
        // R5: registered input loads from the pad
        mode = 3'd1; pin_in = 1'b0; pulse(1'b1, "R5");
        chk("R5", "loads pin", fb_reg, 1'b0);
        chk("R5", "no drive", pin_oe, 1'b0);
        // R6: dedicated input
        mode = 3'd4; pin_in = 1'b1; step("R6");
        chk("R6", "fb_pin from pad", fb_pin, 1'b1);
        chk("R6", "pin_out low", pin_out, 1'b0);
        mode = 3'd6; step("R6");
        chk("R6", "spare code no drive", pin_oe, 1'b0);
        // Sweep every mode, polarity, enable source and clock source
        for (int m = 0; m < 5; m++) begin
            for (int c = 0; c < 8; c++) begin
                mode = 3'(m); pol = c[0]; oe_pt = c[1]; clk_pt = c[2];
                for (int i = 0; i < 40; i++) begin
                    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
                    sum_reg = rs[0]; sum_comb = rs[1]; pt_k = rs[2]; pt_fc = rs[3];
                    ext_clk = rs[4]; pt_clk = rs[5]; ext_oe = rs[6]; pt_oe = rs[7];
                    pin_in = rs[8];
                    pt_preset = rs[9] & rs[10] & rs[11];
                    pt_reset = rs[12] & rs[13] & rs[14];
                    case (m)
                        0: step("R2");
                        1: step("R5");
                        2: step("R3");
                        3: step("R4");
                        default: step("R6");
                    endcase
                end
            end
        end
        finish_run();
    end
endmodule